// File: doc/BRIEF.md
# 16-bit Timer with Compare Output

A 16-bit up-counter that advances on a selectable clock source. The source is either an internal instruction clock, which is the system clock divided by four, or the rising edges of an external clock pin. That pin can be taken through a synchronizer or through a raw edge detector. A power-of-two prescaler of 1, 2, 4 or 8 and an on bit gate the counting. A 16-bit compare register sits beside the counter. When the counter steps onto the compare value, a small compare controller raises a sticky interrupt flag and acts on an output latch.

Software reaches all state through a byte-wide register bus with combinational reads and single-cycle writes. The registers are a control byte, the count bytes, the compare bytes, a 4-bit compare mode code and the flag.

The compare controller is a four-state machine. Its states are CMP_IDLE, CMP_SET, CMP_CLR and CMP_TGL:
- CMP_IDLE means no compare mode. The latch copies the port latch input each cycle.
- CMP_SET drives the latch high on a match.
- CMP_CLR drives the latch low on a match.
- CMP_TGL inverts the latch on a match.

The state changes only on a write to the mode register, and it takes the state that the new code decodes to:
- ENTER_SET is taken on code 1000.
- ENTER_CLR is taken on code 1001.
- ENTER_TGL is taken on code 0010.
- LEAVE is taken on any other code.

The latch keeps its value across a change between compare states. For this reason, swapping between set-on-match and clear-on-match never inverts the output.

Top module: `tmr16_cmp`

## Requirements
- R1: After reset every register reads 0, the timer is stopped, the flag is 0 and the compare output is 0.
- R2: The register addresses are 0 control, 1 count low, 2 count high, 3 compare low, 4 compare high, 5 mode and 6 flag. Address 7 reads 0. The control byte fields are bit 0 on, bit 1 source (1 = external), bit 2 no-sync and bit 3 oscillator enable, which drives `osc_en_o`. Bits 5:4 select the prescale. Control bits 7:6 read 0. The mode register reads back its 4 bits zero-extended. The compare registers read back what was written.
- R3: With the internal source, after a write to the control or count registers at clock edge E0, the count equals start + floor(c / (4·N)) at edge E0+c. N is 1, 2, 4 or 8 for prescale codes 00, 01, 10 and 11. The no-sync bit has no effect on this.
- R4: With the external source, each rising edge of `ext_clk_i` is one source tick. After K slow edges the count has advanced by floor(K / N).
- R5: When the no-sync bit is 1, a rising edge driven between clock edges is counted at the next clock edge. When the no-sync bit is 0, it is counted at the third clock edge.
- R6: With the on bit at 0 the count holds its value under both sources.
- R7: Writes to the count bytes replace one byte each and take priority over counting. The counter wraps from FFFF to 0000.
- R8: A match happens only when the counter steps onto the compare value, including after a wrap. The flag is set at that same edge in every mode. Writing the count equal to the compare value is not a match.
- R9: The flag is cleared only by writing 0 in bit 0 at address 6. Writing 1 leaves it unchanged.
- R10: Mode code 1000 drives the output high on a match, 1001 drives it low, and 0010 inverts it.
- R11: Switching the mode directly between 1000 and 1001, any number of times, keeps the output polarity correct: high after each match under 1000 and low after each match under 1001.
- R12: Under any other mode code the output equals `port_latch_i` one cycle later, and matches do not move it. A compare mode entered from there starts from that copied value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ext_clk_i | input | 1 | External count clock |
| port_latch_i | input | 1 | Port data latch value used outside compare mode |
| cmp_out_o | output | 1 | Compare output latch |
| irq_flag_o | output | 1 | Sticky compare interrupt flag |
| osc_en_o | output | 1 | Oscillator enable bit from the control byte |

## Verification
The bench builds the block with its default parameters:
- 8-bit bus bytes,
- a 2-bit prescale select,
- a divide-by-four instruction clock,
- two synchronizer stages.

These defaults keep the largest prescaled period at 32 cycles, so every combination of prescale, source and sync setting can be swept. The exact edge on which each count step lands is checked against the floor formula. Because the counter is loaded just below the compare value, any 16-bit compare value can be reached in a dozen cycles, including FFFF and values just past the wrap. This allows long alternating runs of set-on-match and clear-on-match within a short simulation.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        CMP_IDLE = 2'd0,
        CMP_SET  = 2'd1,
        CMP_CLR  = 2'd2,
        CMP_TGL  = 2'd3
    } cmp_state_e;

    localparam int          ADDR_W   = 3;
    localparam logic [2:0]  A_CTRL   = 3'd0;
    localparam logic [2:0]  A_CNT_LO = 3'd1;
    localparam logic [2:0]  A_CNT_HI = 3'd2;
    localparam logic [2:0]  A_CMP_LO = 3'd3;
    localparam logic [2:0]  A_CMP_HI = 3'd4;
    localparam logic [2:0]  A_MODE   = 3'd5;
    localparam logic [2:0]  A_FLAG   = 3'd6;

    localparam int          MODE_W   = 4;
    localparam logic [3:0]  MODE_SET = 4'b1000;
    localparam logic [3:0]  MODE_CLR = 4'b1001;
    localparam logic [3:0]  MODE_TGL = 4'b0010;

    // control byte bit positions (software decodes these)
    localparam int B_ON     = 0;
    localparam int B_SRC    = 1;
    localparam int B_NOSYNC = 2;
    localparam int B_OSC    = 3;
    localparam int B_PS     = 4;

    function automatic cmp_state_e mode_to_state(input logic [3:0] code);
        cmp_state_e s;
        case (code)
            MODE_SET: s = CMP_SET;
            MODE_CLR: s = CMP_CLR;
            MODE_TGL: s = CMP_TGL;
            default:  s = CMP_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr16_tick_gen.sv
module tmr16_tick_gen #(
    parameter int DIV_LOG2    = 2,
    parameter int PS_BITS     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               tmr_on,
    input  logic               src_ext,
    input  logic               no_sync,
    input  logic [PS_BITS-1:0] ps_sel,
    input  logic               ext_clk_i,
    output logic               cnt_tick
);

    localparam int PSC_W = (1 << PS_BITS) - 1;

    logic [DIV_LOG2-1:0]    phase_q;
    logic                   instr_tick;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_prev_q;
    logic                   sync_edge;
    logic                   raw_q;
    logic                   raw_edge;
    logic                   ext_edge;
    logic                   src_tick;
    logic                   step;
    logic [PSC_W-1:0]       ps_q;
    logic [PSC_W-1:0]       ps_mask;

    // instruction clock phase, restarted by register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_LOG2'(1);
        end
    end

    assign instr_tick = &phase_q;

    // synchronizer chain for the external clock
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= ext_clk_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b0;
            raw_q       <= 1'b0;
        end else begin
            sync_prev_q <= sync_q[SYNC_STAGES-1];
            raw_q       <= ext_clk_i;
        end
    end

    assign sync_edge = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
    assign raw_edge  = ext_clk_i & ~raw_q;
    assign ext_edge  = no_sync ? raw_edge : sync_edge;
    assign src_tick  = src_ext ? ext_edge : instr_tick;
    assign step      = src_tick & tmr_on & ~restart;

    always_comb begin
        ps_mask = '0;
        for (int i = 0; i < PSC_W; i++) begin
            ps_mask[i] = (ps_sel > PS_BITS'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (restart) begin
            ps_q <= '0;
        end else if (step) begin
            ps_q <= ps_q + PSC_W'(1);
        end
    end

    assign cnt_tick = step & ((ps_q & ps_mask) == ps_mask);

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] cmp_val,
    output logic [2*DATA_W-1:0] cnt_q,
    output logic                match
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_next;
    logic             any_wr;

    assign cnt_next = cnt_q + CNT_W'(1);
    assign any_wr   = wr_lo | wr_hi;
    assign match    = cnt_tick & ~any_wr & (cnt_next == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (cnt_tick) begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PS_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [2*DATA_W-1:0] cnt_val,
    input  logic                match,
    output logic                tmr_on,
    output logic                src_ext,
    output logic                no_sync,
    output logic                osc_en,
    output logic [PS_BITS-1:0]  ps_sel,
    output logic [2*DATA_W-1:0] cmp_val,
    output logic                cnt_wr_lo,
    output logic                cnt_wr_hi,
    output logic                restart,
    output logic                mode_wr,
    output logic                flag_q
);

    localparam int CNT_W  = 2 * DATA_W;
    localparam int CTRL_W = B_PS + PS_BITS;

    logic [CTRL_W-1:0] ctrl_q;
    logic [MODE_W-1:0] mode_q;
    logic              ctrl_wr;
    logic              flag_clr;

    assign ctrl_wr   = bus_we && (bus_addr == A_CTRL);
    assign cnt_wr_lo = bus_we && (bus_addr == A_CNT_LO);
    assign cnt_wr_hi = bus_we && (bus_addr == A_CNT_HI);
    assign mode_wr   = bus_we && (bus_addr == A_MODE);
    assign flag_clr  = bus_we && (bus_addr == A_FLAG) && !bus_wdata[0];
    assign restart   = ctrl_wr | cnt_wr_lo | cnt_wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            cmp_val <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_CTRL:   ctrl_q                   <= bus_wdata[CTRL_W-1:0];
                A_CMP_LO: cmp_val[DATA_W-1:0]      <= bus_wdata;
                A_CMP_HI: cmp_val[CNT_W-1:DATA_W]  <= bus_wdata;
                A_MODE:   mode_q                   <= bus_wdata[MODE_W-1:0];
                default:  ;
            endcase
        end
    end

    // sticky flag: a match wins over a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (match)    flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign tmr_on  = ctrl_q[B_ON];
    assign src_ext = ctrl_q[B_SRC];
    assign no_sync = ctrl_q[B_NOSYNC];
    assign osc_en  = ctrl_q[B_OSC];
    assign ps_sel  = ctrl_q[B_PS +: PS_BITS];

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = DATA_W'(ctrl_q);
            A_CNT_LO: bus_rdata = cnt_val[DATA_W-1:0];
            A_CNT_HI: bus_rdata = cnt_val[CNT_W-1:DATA_W];
            A_CMP_LO: bus_rdata = cmp_val[DATA_W-1:0];
            A_CMP_HI: bus_rdata = cmp_val[CNT_W-1:DATA_W];
            A_MODE:   bus_rdata = DATA_W'(mode_q);
            A_FLAG:   bus_rdata = DATA_W'(flag_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr16_cmp_fsm.sv
module tmr16_cmp_fsm
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              match,
    input  logic              port_latch_i,
    output cmp_state_e        state_q,
    output logic              out_q
);

    cmp_state_e state_d;
    logic       out_d;

    // transitions: ENTER_SET, ENTER_CLR, ENTER_TGL, LEAVE on a mode write
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = mode_to_state(mode_code);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_IDLE;
        else        state_q <= state_d;
    end

    // output latch acts on the state in force before any mode write
    always_comb begin
        out_d = out_q;
        unique case (state_q)
            CMP_IDLE: out_d = port_latch_i;
            CMP_SET:  if (match) out_d = 1'b1;
            CMP_CLR:  if (match) out_d = 1'b0;
            CMP_TGL:  if (match) out_d = ~out_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

endmodule

// File: rtl/tmr16_cmp.sv
module tmr16_cmp
    import tmr16_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PS_BITS     = 2,
    parameter int DIV_LOG2    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk_i,
    input  logic              port_latch_i,
    output logic              cmp_out_o,
    output logic              irq_flag_o,
    output logic              osc_en_o
);

    localparam int CNT_W  = 2 * DATA_W;
    localparam int CTRL_W = B_PS + PS_BITS;

    logic               tmr_on;
    logic               src_ext;
    logic               no_sync;
    logic [PS_BITS-1:0] ps_sel;
    logic [CNT_W-1:0]   cmp_val;
    logic [CNT_W-1:0]   cnt_q;
    logic               cnt_wr_lo;
    logic               cnt_wr_hi;
    logic               restart;
    logic               mode_wr;
    logic               cnt_tick;
    logic               cmp_match;
    cmp_state_e         cmp_state;

    tmr16_regs #(.DATA_W(DATA_W), .PS_BITS(PS_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_val   (cnt_q),
        .match     (cmp_match),
        .tmr_on    (tmr_on),
        .src_ext   (src_ext),
        .no_sync   (no_sync),
        .osc_en    (osc_en_o),
        .ps_sel    (ps_sel),
        .cmp_val   (cmp_val),
        .cnt_wr_lo (cnt_wr_lo),
        .cnt_wr_hi (cnt_wr_hi),
        .restart   (restart),
        .mode_wr   (mode_wr),
        .flag_q    (irq_flag_o)
    );

    tmr16_tick_gen #(
        .DIV_LOG2    (DIV_LOG2),
        .PS_BITS     (PS_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .tmr_on    (tmr_on),
        .src_ext   (src_ext),
        .no_sync   (no_sync),
        .ps_sel    (ps_sel),
        .ext_clk_i (ext_clk_i),
        .cnt_tick  (cnt_tick)
    );

    tmr16_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_tick (cnt_tick),
        .wr_lo    (cnt_wr_lo),
        .wr_hi    (cnt_wr_hi),
        .wdata    (bus_wdata),
        .cmp_val  (cmp_val),
        .cnt_q    (cnt_q),
        .match    (cmp_match)
    );

    tmr16_cmp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_code    (bus_wdata[MODE_W-1:0]),
        .match        (cmp_match),
        .port_latch_i (port_latch_i),
        .state_q      (cmp_state),
        .out_q        (cmp_out_o)
    );

endmodule

// File: rtl/tmr16_cmp_chk.sv
module tmr16_cmp_chk
    import tmr16_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CTRL_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                port_latch_i,
    input logic                cmp_out_o,
    input logic                irq_flag_o,
    input logic                tmr_on,
    input logic [2*DATA_W-1:0] cnt_val,
    input logic                cnt_wr_lo,
    input logic                cnt_wr_hi,
    input logic                match,
    input cmp_state_e          state
);

    localparam int CNT_W = 2 * DATA_W;

    AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> ((bus_rdata >> CTRL_W) == '0)); // R2

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_on && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt_val)); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_lo && !cnt_wr_hi) |=>
        (cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) + CNT_W'(1))); // R7

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_flag_o); // R8

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !(bus_we && bus_addr == A_FLAG && !bus_wdata[0])) |=> irq_flag_o); // R9

    AST_SET_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMP_SET && match) |=> cmp_out_o); // R10

    AST_CLR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMP_CLR && match) |=> !cmp_out_o); // R11

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMP_TGL && match) |=> (cmp_out_o != $past(cmp_out_o))); // R10

    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CMP_IDLE) |=> (cmp_out_o == $past(port_latch_i))); // R12

endmodule

bind tmr16_cmp tmr16_cmp_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .port_latch_i (port_latch_i),
    .cmp_out_o    (cmp_out_o),
    .irq_flag_o   (irq_flag_o),
    .tmr_on       (tmr_on),
    .cnt_val      (cnt_q),
    .cnt_wr_lo    (cnt_wr_lo),
    .cnt_wr_hi    (cnt_wr_hi),
    .match        (cmp_match),
    .state        (cmp_state)
);

// File: tb/tmr16_cmp_bench.sv
`timescale 1ns/1ps
module tmr16_cmp_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext = 1'b0;
    logic       port = 1'b0;
    logic       cmp_out;
    logic       irq_flag;
    logic       osc_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tmr16_cmp u_tmr16_cmp (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ext_clk_i    (ext),
        .port_latch_i (port),
        .cmp_out_o    (cmp_out),
        .irq_flag_o   (irq_flag),
        .osc_en_o     (osc_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(3'd1, lo);
        rd(3'd2, hi);
        v = {hi, lo};
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd1, v[7:0]);
        wr(3'd2, v[15:8]);
    endtask

    // counter loaded 3 below the compare value, internal clock 1:1
    task automatic run_cmp(input logic [15:0] cv, input logic exp_out, input string tag);
        logic [15:0] st;
        st = cv - 16'd3;
        wr(3'd0, 8'h00);
        wr(3'd6, 8'h00);
        set_cnt(st);
        wr(3'd3, cv[7:0]);
        wr(3'd4, cv[15:8]);
        wr(3'd0, 8'h01);
        edges(11);
        chk({tag, " R8 no flag before match"}, int'(irq_flag), 0);
        edges(1);
        chk({tag, " R8 flag at match"}, int'(irq_flag), 1);
        chk({tag, " output after match"}, int'(cmp_out), int'(exp_out));
        wr(3'd0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        int v, v2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b);
            chk($sformatf("R1 reset read addr %0d", a), int'(b), 0);
        end
        chk("R1 reset output", int'(cmp_out), 0);
        chk("R1 reset flag", int'(irq_flag), 0);
        chk("R1 reset osc enable", int'(osc_en), 0);

        // R2 layout and readback
        wr(3'd0, 8'hF8);
        rd(3'd0, b);
        chk("R2 ctrl upper bits read zero", int'(b), 'h38);
        chk("R2 osc enable pin", int'(osc_en), 1);
        wr(3'd0, 8'h00);
        wr(3'd5, 8'hFA);
        rd(3'd5, b);
        chk("R2 mode readback", int'(b), 'h0A);
        wr(3'd5, 8'h00);
        wr(3'd3, 8'hA5);
        wr(3'd4, 8'h5A);
        rd(3'd3, b);
        chk("R2 compare low", int'(b), 'hA5);
        rd(3'd4, b);
        chk("R2 compare high", int'(b), 'h5A);

        // R7 byte writes
        set_cnt(16'h1234);
        rd_cnt(v);
        chk("R7 count byte writes", v, 'h1234);

        // R3 internal source sweep over prescale and sync bit
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                int n;
                n = 1 << p;
                set_cnt(16'h0000);
                wr(3'd0, 8'((p << 4) | (s << 2) | 1));
                edges(4 * n - 1);
                rd_cnt(v);
                chk($sformatf("R3 p=%0d s=%0d before first step", p, s), v, 0);
                edges(1);
                rd_cnt(v);
                chk($sformatf("R3 p=%0d s=%0d first step", p, s), v, 1);
                edges(12 * n);
                rd_cnt(v);
                chk($sformatf("R3 p=%0d s=%0d after 16N cycles", p, s), v, 4);
            end
        end

        // R6 off holds under internal and external source
        wr(3'd0, 8'h00);
        rd_cnt(v);
        edges(40);
        rd_cnt(v2);
        chk("R6 internal off holds", v2, v);
        wr(3'd0, 8'h02);
        for (int k = 0; k < 4; k++) begin
            ext = 1'b1; edges(3); ext = 1'b0; edges(3);
        end
        rd_cnt(v2);
        chk("R6 external off holds", v2, v);

        // R4 external sweep
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                wr(3'd0, 8'h00);
                set_cnt(16'h0000);
                wr(3'd0, 8'((p << 4) | (s << 2) | 3));
                for (int k = 0; k < 12; k++) begin
                    ext = 1'b1; edges(3); ext = 1'b0; edges(3);
                end
                edges(4);
                rd_cnt(v);
                chk($sformatf("R4 ext p=%0d nosync=%0d", p, s), v, 12 >> p);
            end
        end

        // R5 latency
        wr(3'd0, 8'h00);
        set_cnt(16'h0000);
        wr(3'd0, 8'h07);
        ext = 1'b1;
        edges(1);
        rd_cnt(v);
        chk("R5 unsynced edge counted next edge", v, 1);
        ext = 1'b0;
        edges(4);
        wr(3'd0, 8'h00);
        set_cnt(16'h0000);
        wr(3'd0, 8'h03);
        ext = 1'b1;
        edges(2);
        rd_cnt(v);
        chk("R5 synced edge not yet counted", v, 0);
        edges(1);
        rd_cnt(v);
        chk("R5 synced edge counted third edge", v, 1);
        ext = 1'b0;
        edges(4);
        wr(3'd0, 8'h00);

        // R10 R11 alternating set and clear, including wrap
        for (int i = 0; i < 6; i++) begin
            logic [15:0] cv;
            case (i)
                0: cv = 16'h1234;
                1: cv = 16'h0101;
                2: cv = 16'hFFFF;
                3: cv = 16'h0000;
                4: cv = 16'h0002;
                default: cv = 16'h8000;
            endcase
            wr(3'd5, (i % 2 == 0) ? 8'h08 : 8'h09);
            run_cmp(cv, (i % 2 == 0), $sformatf("R11 alt %0d", i));
        end

        // R10 toggle
        wr(3'd5, 8'h02);
        run_cmp(16'h0400, 1'b1, "R10 toggle first");
        run_cmp(16'h0500, 1'b0, "R10 toggle second");

        // R12 leaving compare mode follows port
        wr(3'd5, 8'h08);
        run_cmp(16'h0600, 1'b1, "R10 set before leave");
        port = 1'b0;
        wr(3'd5, 8'h00);
        edges(1);
        chk("R12 leave follows port low", int'(cmp_out), 0);
        port = 1'b1;
        edges(1);
        chk("R12 follows port high", int'(cmp_out), 1);
        wr(3'd5, 8'h09);
        chk("R12 enter clear starts from port", int'(cmp_out), 1);
        run_cmp(16'h0700, 1'b0, "R12 clear after idle");
        wr(3'd5, 8'h0A);
        port = 1'b1;
        edges(1);
        chk("R12 other code follows port", int'(cmp_out), 1);
        run_cmp(16'h0800, 1'b1, "R12 match ignored when idle");
        port = 1'b0;
        edges(1);

        // R9 flag clear rules
        chk("R9 flag set after match", int'(irq_flag), 1);
        wr(3'd6, 8'h01);
        chk("R9 writing one keeps flag", int'(irq_flag), 1);
        wr(3'd6, 8'hFE);
        chk("R9 writing zero clears flag", int'(irq_flag), 0);
        wr(3'd6, 8'h01);
        chk("R9 writing one does not set flag", int'(irq_flag), 0);

        // R8 writing count equal to compare is no match
        wr(3'd3, 8'h55);
        wr(3'd4, 8'h66);
        set_cnt(16'h6655);
        edges(3);
        chk("R8 write equal no flag", int'(irq_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule